// File: doc/BRIEF.md
# Capture/Compare Timer Channel

This block is one 16-bit capture/compare channel that takes its time base from one of two free-running timer count buses. In capture mode it watches an external input pin, synchronises it, and on the chosen transition copies the selected timer's count into its value register and raises a one-cycle interrupt. In compare mode it watches the selected count and, in the cycle the count arrives at the stored value, raises the interrupt and, in the toggling variant, flips its output pin.

Software reaches the channel through two plain write strobes, one for the configuration (mode, edge choice, timer choice) and one for the value, and it reads the value back on a dedicated bus. There is no streaming data path, so there is no valid/ready handshake and no back-pressure: every port is a plain level or single-cycle strobe, sampled on the rising clock edge. Arbitration between many such channels sits outside this block.

Top module: `ccr_channel`

## Requirements
- R1: While rst_n is low, val_rdata is 0, irq is 0, cmp_pin is 0 and the mode is disabled.
- R2: A val_we strobe loads val_wdata into the value register, readable on val_rdata after the next rising edge.
- R3: In capture mode (mode 01), a pin transition first sampled at rising edge k is captured at edge k+2: the value register takes the selected timer count present at edge k+2.
- R4: The edge choice is encoded 00 no trigger, 01 rising only, 10 falling only, 11 either edge; a transition of a kind that is not chosen leaves the value register and irq untouched.
- R5: Every capture drives irq high for exactly the one cycle after the capturing edge.
- R6: In compare modes (10 and 11), irq goes high for one cycle after the edge at which the selected count changes to equal the value register; a count that stays equal does not fire again, and the unselected timer never fires it.
- R7: In mode 11 each compare hit inverts cmp_pin at the same edge that raises irq; in every other mode cmp_pin holds.
- R8: When a capture and a val_we strobe land on the same edge, the captured count is stored and the write is lost.
- R9: cfg_tsel 0 selects tmr_a and 1 selects tmr_b; a configuration write that changes the selection discards any transition still in the synchroniser, so it never causes a capture.
- R10: In mode 00 the channel raises no interrupt and performs no capture.
- R11: In capture mode a count equal to the stored value raises no interrupt and leaves cmp_pin unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 2 | Mode: 00 off, 01 capture, 10 compare with irq, 11 compare with irq and pin toggle |
| cfg_edge | input | 2 | Capture trigger: 00 none, 01 rising, 10 falling, 11 both |
| cfg_tsel | input | 1 | Time base: 0 tmr_a, 1 tmr_b |
| val_we | input | 1 | Value register write strobe |
| val_wdata | input | 16 | Value register write data |
| val_rdata | output | 16 | Value register contents |
| tmr_a | input | 16 | Count of the first timer |
| tmr_b | input | 16 | Count of the second timer |
| cap_pin | input | 1 | Asynchronous capture input |
| cmp_pin | output | 1 | Compare output, toggled in mode 11 |
| irq | output | 1 | One-cycle interrupt request |

## Verification
Two collisions can land in one cycle: a capture and a software write on the same edge, and a timer re-selection while a pin transition is still travelling through the synchroniser. The bench provokes the first by timing a val_we strobe onto the exact edge that the capture latency predicts, and judges it by reading back the captured count rather than the written word, also confirming that the write survives when the chosen edge kind did not fire. The second is provoked by changing cfg_tsel one edge after the pin moves, and judged by seeing no irq and an unchanged value over the following cycles.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  typedef enum logic [1:0] {
    CCR_OFF     = 2'b00,
    CCR_CAP     = 2'b01,
    CCR_CMP_IRQ = 2'b10,
    CCR_CMP_TGL = 2'b11
  } ccr_mode_e;

  typedef enum logic [1:0] {
    TRIG_NONE = 2'b00,
    TRIG_RISE = 2'b01,
    TRIG_FALL = 2'b10,
    TRIG_ANY  = 2'b11
  } ccr_trig_e;
endpackage

// File: rtl/ccr_edge_sync.sv
module ccr_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_i,
  input  logic       clr_i,
  input  logic [1:0] trig_i,
  output logic       evt_o
);
  localparam int DEPTH = SYNC_STAGES + 1;

  // sh[0..SYNC_STAGES-1] synchroniser, sh[SYNC_STAGES] history for edge detection
  logic [DEPTH-1:0] sh;
  logic             rise, fall;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh <= '0;
    end else if (clr_i) begin
      // flush: every stage takes the latest sample, so no transition remains in flight
      sh <= {DEPTH{sh[0]}};
    end else begin
      sh <= {sh[DEPTH-2:0], pin_i};
    end
  end

  assign rise  = sh[SYNC_STAGES-1] & ~sh[SYNC_STAGES];
  assign fall  = ~sh[SYNC_STAGES-1] & sh[SYNC_STAGES];
  assign evt_o = ~clr_i & ((trig_i[0] & rise) | (trig_i[1] & fall));
endmodule

// File: rtl/ccr_match.sv
module ccr_match #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] ref_i,
  output logic         hit_o
);
  logic [W-1:0] cnt_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_prev <= '0;
    else        cnt_prev <= cnt_i;
  end

  // fire only on arrival at the reference, never while parked on it
  assign hit_o = (cnt_i == ref_i) && (cnt_i != cnt_prev);
endmodule

// File: rtl/ccr_channel.sv
module ccr_channel #(
  parameter int W           = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_we,
  input  logic [1:0]   cfg_mode,
  input  logic [1:0]   cfg_edge,
  input  logic         cfg_tsel,
  input  logic         val_we,
  input  logic [W-1:0] val_wdata,
  output logic [W-1:0] val_rdata,
  input  logic [W-1:0] tmr_a,
  input  logic [W-1:0] tmr_b,
  input  logic         cap_pin,
  output logic         cmp_pin,
  output logic         irq
);
  import ccr_pkg::*;

  localparam int NUM_TB = 2;

  ccr_mode_e    mode_q;
  logic [1:0]   trig_q;
  logic         tsel_q;
  logic [W-1:0] val_q;
  logic         pin_q;
  logic         irq_q;

  logic [W-1:0] tb_bus [NUM_TB];
  logic [W-1:0] sel_cnt;
  logic         tsel_chg;
  logic         edge_evt;
  logic         cmp_hit;
  logic         cap_fire;
  logic         cmp_fire;

  assign tb_bus[0] = tmr_a;
  assign tb_bus[1] = tmr_b;
  assign sel_cnt   = tb_bus[tsel_q];
  assign tsel_chg  = cfg_we && (cfg_tsel != tsel_q);

  ccr_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (cap_pin),
    .clr_i  (tsel_chg),
    .trig_i (trig_q),
    .evt_o  (edge_evt)
  );

  ccr_match #(.W(W)) u_match (
    .clk   (clk),
    .rst_n (rst_n),
    .cnt_i (sel_cnt),
    .ref_i (val_q),
    .hit_o (cmp_hit)
  );

  assign cap_fire = (mode_q == CCR_CAP) && edge_evt;
  assign cmp_fire = mode_q[1] && cmp_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= CCR_OFF;
      trig_q <= TRIG_NONE;
      tsel_q <= 1'b0;
    end else if (cfg_we) begin
      mode_q <= ccr_mode_e'(cfg_mode);
      trig_q <= cfg_edge;
      tsel_q <= cfg_tsel;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val_q <= '0;
    end else if (cap_fire) begin
      val_q <= sel_cnt;
    end else if (val_we) begin
      val_q <= val_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      pin_q <= 1'b0;
    end else begin
      irq_q <= cap_fire | cmp_fire;
      if (cmp_fire && (mode_q == CCR_CMP_TGL)) pin_q <= ~pin_q;
    end
  end

  assign val_rdata = val_q;
  assign cmp_pin   = pin_q;
  assign irq       = irq_q;
endmodule

// File: rtl/ccr_channel_chk.sv
module ccr_channel_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   mode_q,
  input logic         tsel_q,
  input logic [W-1:0] tmr_a,
  input logic [W-1:0] tmr_b,
  input logic         cap_evt,
  input logic         val_we,
  input logic [W-1:0] val_wdata,
  input logic [W-1:0] val_q,
  input logic         irq,
  input logic         cmp_pin
);
  // R3: a capture event stores the count of the selected timer
  p_cap_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b01 && cap_evt) |=> (val_q == $past(tsel_q ? tmr_b : tmr_a)));

  // R8: a write on the capturing edge is overridden
  p_cap_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b01 && cap_evt && val_we && (val_wdata != (tsel_q ? tmr_b : tmr_a)))
      |=> (val_q != $past(val_wdata)));

  // R2: a write without a competing capture lands
  p_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (val_we && !(mode_q == 2'b01 && cap_evt)) |=> (val_q == $past(val_wdata)));

  // R5: in capture mode irq follows capture events one-for-one
  p_cap_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b01) |=> (irq == $past(cap_evt)));

  // R10: disabled channel stays silent
  p_off_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b00) |=> !irq);

  // R7: output pin holds outside the toggling mode
  p_pin_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != 2'b11) |=> $stable(cmp_pin));

  // R7: in the toggling mode every interrupt flips the pin and nothing else does
  p_tgl_follows_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b11) |=> ((cmp_pin != $past(cmp_pin)) == irq));
endmodule

bind ccr_channel ccr_channel_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_q    (mode_q),
  .tsel_q    (tsel_q),
  .tmr_a     (tmr_a),
  .tmr_b     (tmr_b),
  .cap_evt   (edge_evt),
  .val_we    (val_we),
  .val_wdata (val_wdata),
  .val_q     (val_q),
  .irq       (irq),
  .cmp_pin   (cmp_pin)
);

// File: tb/ccr_channel_tb.sv
module ccr_channel_tb;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         cfg_we;
  logic [1:0]   cfg_mode;
  logic [1:0]   cfg_edge;
  logic         cfg_tsel;
  logic         val_we;
  logic [W-1:0] val_wdata;
  logic [W-1:0] val_rdata;
  logic [W-1:0] tmr_a;
  logic [W-1:0] tmr_b;
  logic         cap_pin;
  logic         cmp_pin;
  logic         irq;

  int errs   = 0;
  int checks = 0;
  bit tmr_run = 1'b0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  ccr_channel #(.W(W), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .cfg_edge(cfg_edge), .cfg_tsel(cfg_tsel), .val_we(val_we),
    .val_wdata(val_wdata), .val_rdata(val_rdata), .tmr_a(tmr_a),
    .tmr_b(tmr_b), .cap_pin(cap_pin), .cmp_pin(cmp_pin), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (tmr_run) begin
      tmr_a = tmr_a + 16'd1;
      tmr_b = tmr_b + 16'd3;
    end
  endtask

  task automatic cfg(input logic [1:0] m, input logic [1:0] e, input logic t);
    cfg_mode = m; cfg_edge = e; cfg_tsel = t; cfg_we = 1'b1;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic wr(input logic [W-1:0] d);
    val_wdata = d; val_we = 1'b1;
    step();
    val_we = 1'b0;
  endtask

  // pin transition, then capture expected two edges after first sampling
  task automatic do_cap(input logic [1:0] e, input bit rising, input bit ts, input bit with_wr);
    logic [W-1:0] ea, eb, expv;
    bit hit;
    tmr_run = 1'b0;
    cap_pin = ~rising;
    cfg(2'b01, e, ts);
    repeat (4) step();
    wr(16'h5A5A);
    tmr_run = 1'b1;
    step();
    cap_pin = rising;
    ea = tmr_a + 16'd2;
    eb = tmr_b + 16'd6;
    hit = (e == 2'b11) || (e == 2'b01 && rising) || (e == 2'b10 && !rising);
    expv = hit ? (ts ? eb : ea) : (with_wr ? 16'hC3C3 : 16'h5A5A);
    step();
    step();
    if (with_wr) begin val_wdata = 16'hC3C3; val_we = 1'b1; end
    step();
    val_we = 1'b0;
    if (with_wr) chk("R8 capture vs write", val_rdata, expv);
    else         chk("R3/R4/R9 captured value", val_rdata, expv);
    chk("R5 irq on capture", irq, hit);
    step();
    chk("R5 irq one cycle only", irq, 1'b0);
    tmr_run = 1'b0;
  endtask

  task automatic do_cmp(input logic [1:0] m, input bit ts);
    logic [W-1:0] x, prevx;
    logic pin0;
    bit exp_irq;
    tmr_run = 1'b0;
    cap_pin = 1'b0;
    cfg(m, 2'b00, ts);
    tmr_a = '0; tmr_b = '0;
    wr(16'd13);
    chk("R2 readback", val_rdata, 16'd13);
    step(); step();
    pin0 = cmp_pin;
    prevx = '0;
    for (int i = 0; i < 22; i++) begin
      x = (i < 14) ? 16'(i) : ((i < 17) ? 16'd13 : 16'(i - 3));
      if (ts) begin tmr_b = x; tmr_a = x + 16'd5; end
      else    begin tmr_a = x; tmr_b = x + 16'd5; end
      step();
      exp_irq = m[1] && (x == 16'd13) && (prevx != 16'd13);
      if (m == 2'b00)      chk("R10 disabled no irq", irq, 1'b0);
      else if (m == 2'b01) chk("R11 capture mode no compare irq", irq, 1'b0);
      else                 chk("R6 compare irq", irq, exp_irq);
      prevx = x;
    end
    chk("R7 output pin", cmp_pin, pin0 ^ (m == 2'b11));
  endtask

  initial begin
    int n;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_mode = '0; cfg_edge = '0; cfg_tsel = 1'b0;
    val_we = 1'b0; val_wdata = '0; tmr_a = '0; tmr_b = '0; cap_pin = 1'b0;
    repeat (3) step();
    chk("R1 value at reset", val_rdata, 16'h0000);
    chk("R1 irq at reset", irq, 1'b0);
    chk("R1 pin at reset", cmp_pin, 1'b0);
    rst_n = 1'b1;
    step();
    wr(16'hBEEF);
    chk("R2 write", val_rdata, 16'hBEEF);

    // R10: disabled mode ignores pin edges
    tmr_a = 16'h0777;
    cfg(2'b00, 2'b11, 1'b0);
    cap_pin = 1'b1;
    n = 0;
    repeat (5) begin step(); if (irq) n++; end
    chk("R10 no irq when off", n, 0);
    chk("R10 no capture when off", val_rdata, 16'hBEEF);

    // R3 R4 R9: sweep edge choice x transition x timer
    for (int e = 0; e < 4; e++)
      for (int r = 0; r < 2; r++)
        for (int t = 0; t < 2; t++)
          do_cap(2'(e), bit'(r), bit'(t), 1'b0);

    // R8: write on the capturing edge
    do_cap(2'b11, 1'b1, 1'b0, 1'b1);
    do_cap(2'b01, 1'b1, 1'b1, 1'b1);
    do_cap(2'b10, 1'b1, 1'b0, 1'b1);

    // R9: re-selection flushes an in-flight transition
    tmr_run = 1'b0;
    cap_pin = 1'b0;
    cfg(2'b01, 2'b01, 1'b0);
    repeat (4) step();
    wr(16'h5A5A);
    cap_pin = 1'b1;
    step();
    cfg(2'b01, 2'b01, 1'b1);
    n = 0;
    repeat (4) begin step(); if (irq) n++; end
    chk("R9 flushed edge irq", n, 0);
    chk("R9 flushed edge value", val_rdata, 16'h5A5A);

    // R6 R7 R10 R11: compare sweep over every mode and timer
    for (int m = 0; m < 4; m++)
      for (int t = 0; t < 2; t++)
        do_cmp(2'(m), bit'(t));

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule